// File: doc/BRIEF.md
# Tape Record Framer and Parser

This block sits between a host data path and a byte-serial tape image. On a write command it turns a host record into a framed byte stream: a 32-bit length sent least-significant byte first, the record bytes, a zero filler byte when the length is odd, and the same 32-bit length again. A separate command writes a file mark, a lone length word of zero. On a read command it takes the next frame from the tape byte stream and delivers the record bytes to the host through a valid/ready stream. When the read finishes it reports the record length and the outcome flags.

A read request carries a byte budget. If the record is longer than the budget, only the budgeted bytes go to the host. The rest of the record, the filler and the trailer are still consumed so that the stream stays aligned on the next frame. Two file marks in a row, by any mix of reads and writes, are reported as logical end of tape. Each command ends with a one-cycle completion pulse, and the status outputs are updated in that same cycle.

Top module: `tfr_codec`

## Requirements
- R1: A write record command with length L>0 emits L as four bytes least-significant first, then the L host bytes in order, then L again as four bytes least-significant first.
- R2: When L is odd, one byte of value 0x00 is emitted between the last data byte and the trailing length.
- R3: A file mark command (cmd_op_i bit 1 set), or a write record command with L=0, emits exactly four 0x00 bytes and completes with sts_tmark_o=1 and sts_len_o=0.
- R4: A read command (cmd_op_i=0) delivers the record's data bytes in tape order on rd_data_o and completes with sts_len_o equal to the leading length.
- R5: On read, a record longer than the requested count sets sts_rle_o, delivers only the requested number of bytes, and consumes the remainder of the frame including the trailer.
- R6: On read, a record no longer than the requested count delivers all its bytes and leaves sts_rle_o clear.
- R7: On read, the filler byte of an odd-length record is consumed and never delivered to the host.
- R8: On read, a trailing length that differs from the leading length sets sts_fmt_o.
- R9: On read, a leading length of zero completes as a file mark (sts_tmark_o=1), delivers nothing, and consumes only those four bytes.
- R10: sts_eot_o is set when a completed command is a file mark and the command completed just before it was also a file mark; any other completion clears it.
- R11: On read, a leading length above MAX_LEN sets sts_par_o, delivers nothing, and consumes no byte after the length word.
- R12: cmd_ready_o is high only while no command is in progress; a command offered while busy is not taken, and while idle tp_out_valid_o, rd_valid_o, wr_ready_o and tp_in_ready_o are low.
- R13: done_o pulses for exactly one cycle per accepted command, and the status outputs change only in that cycle.

Ports for reset state: after reset cmd_ready_o=1, done_o=0, all status outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Command accepted when high with cmd_valid_i |
| cmd_op_i | input | 2 | 0 read, 1 write record, 2 or 3 write file mark |
| cmd_len_i | input | LEN_W | Write length or read byte budget |
| wr_data_i | input | 8 | Host byte to write |
| wr_valid_i | input | 1 | Host byte valid |
| wr_ready_o | output | 1 | Host byte taken |
| tp_out_data_o | output | 8 | Framed byte to tape |
| tp_out_valid_o | output | 1 | Framed byte valid |
| tp_out_ready_i | input | 1 | Tape takes byte |
| tp_in_data_i | input | 8 | Byte from tape |
| tp_in_valid_i | input | 1 | Tape byte valid |
| tp_in_ready_o | output | 1 | Tape byte taken |
| rd_data_o | output | 8 | Record byte to host |
| rd_valid_o | output | 1 | Record byte valid |
| rd_ready_i | input | 1 | Host takes record byte |
| done_o | output | 1 | One-cycle completion pulse |
| sts_len_o | output | 32 | Record length of last command |
| sts_tmark_o | output | 1 | Last command was a file mark |
| sts_eot_o | output | 1 | Second consecutive file mark |
| sts_rle_o | output | 1 | Record longer than read budget |
| sts_fmt_o | output | 1 | Trailer did not match header |
| sts_par_o | output | 1 | Header above MAX_LEN |

## Verification
The hardest cases to reach are the read faults: trailers that disagree with headers and headers above the length limit. The block's own writer never produces either. The bench therefore assembles tape frames byte by byte and feeds them in directly. Budget-truncated reads are the other awkward area, because bytes are skipped internally while the host stalls and the tape side pauses at random. These reads are driven with random valid and ready gaps on both streams. Each one is followed by a check that the whole frame was consumed and that the next frame still parses cleanly.

// File: rtl/tfr_pkg.sv
package tfr_pkg;
  typedef struct packed {
    logic [31:0] len;
    logic        tmark;
    logic        rle;
    logic        fmt;
    logic        par;
  } tfr_res_t;

  typedef enum logic [2:0] {W_IDLE, W_HDR, W_DATA, W_PAD, W_TRL, W_DONE} wr_st_e;
  typedef enum logic [2:0] {R_IDLE, R_HDR, R_CHK, R_DATA, R_PAD, R_TRL, R_DONE} rd_st_e;
endpackage

// File: rtl/tfr_writer.sv
module tfr_writer
  import tfr_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             mark_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [7:0]       wr_data_i,
  input  logic             wr_valid_i,
  output logic             wr_ready_o,
  output logic [7:0]       tp_data_o,
  output logic             tp_valid_o,
  input  logic             tp_ready_i,
  output logic             busy_o,
  output logic             done_o,
  output tfr_res_t         res_o
);
  localparam logic [LEN_W-1:0] ONE_L = LEN_W'(1);

  wr_st_e           st_q;
  logic [31:0]      len_q;
  logic [LEN_W-1:0] cnt_q;
  logic [1:0]       bidx_q;
  logic             fire;
  logic [LEN_W-1:0] last_idx;

  assign last_idx = len_q[LEN_W-1:0] - ONE_L;
  assign fire     = tp_valid_o && tp_ready_i;

  always_comb begin
    tp_valid_o = 1'b0;
    tp_data_o  = 8'h00;
    wr_ready_o = 1'b0;
    unique case (st_q)
      W_HDR, W_TRL: begin
        tp_valid_o = 1'b1;
        tp_data_o  = len_q[{bidx_q, 3'b000} +: 8];
      end
      W_DATA: begin
        tp_valid_o = wr_valid_i;
        tp_data_o  = wr_data_i;
        wr_ready_o = tp_ready_i;
      end
      W_PAD: tp_valid_o = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= W_IDLE;
      len_q  <= '0;
      cnt_q  <= '0;
      bidx_q <= '0;
    end else begin
      unique case (st_q)
        W_IDLE: if (start_i) begin
          len_q  <= mark_i ? 32'd0 : 32'(len_i);
          bidx_q <= '0;
          st_q   <= W_HDR;
        end
        W_HDR: if (fire) begin
          bidx_q <= bidx_q + 2'd1;
          if (bidx_q == 2'd3) begin
            cnt_q <= '0;
            st_q  <= (len_q == 32'd0) ? W_DONE : W_DATA;
          end
        end
        W_DATA: if (fire) begin
          cnt_q <= cnt_q + ONE_L;
          if (cnt_q == last_idx) st_q <= len_q[0] ? W_PAD : W_TRL;
        end
        W_PAD: if (fire) st_q <= W_TRL;
        W_TRL: if (fire) begin
          bidx_q <= bidx_q + 2'd1;
          if (bidx_q == 2'd3) st_q <= W_DONE;
        end
        W_DONE:  st_q <= W_IDLE;
        default: st_q <= W_IDLE;
      endcase
    end
  end

  assign busy_o      = (st_q != W_IDLE);
  assign done_o      = (st_q == W_DONE);
  assign res_o.len   = len_q;
  assign res_o.tmark = (len_q == 32'd0);
  assign res_o.rle   = 1'b0;
  assign res_o.fmt   = 1'b0;
  assign res_o.par   = 1'b0;
endmodule

// File: rtl/tfr_reader.sv
module tfr_reader
  import tfr_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int MAX_LEN = 4096
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [7:0]       tp_data_i,
  input  logic             tp_valid_i,
  output logic             tp_ready_o,
  output logic [7:0]       rd_data_o,
  output logic             rd_valid_o,
  input  logic             rd_ready_i,
  output logic             busy_o,
  output logic             done_o,
  output tfr_res_t         res_o
);
  localparam int CNT_W = $clog2(MAX_LEN + 1);
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

  rd_st_e           st_q;
  logic [31:0]      hdr_q;
  logic [23:0]      trl_q;
  logic [LEN_W-1:0] req_q;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       bidx_q;
  logic             tmark_q, par_q, fmt_q;
  logic             fire, deliver;
  logic [CNT_W-1:0] last_idx;

  assign last_idx = hdr_q[CNT_W-1:0] - ONE_C;
  assign deliver  = (32'(cnt_q) < 32'(req_q));
  assign fire     = tp_valid_i && tp_ready_o;
  assign rd_data_o = tp_data_i;

  always_comb begin
    tp_ready_o = 1'b0;
    rd_valid_o = 1'b0;
    unique case (st_q)
      R_HDR, R_PAD, R_TRL: tp_ready_o = 1'b1;
      R_DATA: begin
        if (deliver) begin
          rd_valid_o = tp_valid_i;
          tp_ready_o = rd_ready_i;
        end else begin
          tp_ready_o = 1'b1;  // bytes beyond the budget are skipped
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= R_IDLE;
      hdr_q   <= '0;
      trl_q   <= '0;
      req_q   <= '0;
      cnt_q   <= '0;
      bidx_q  <= '0;
      tmark_q <= 1'b0;
      par_q   <= 1'b0;
      fmt_q   <= 1'b0;
    end else begin
      unique case (st_q)
        R_IDLE: if (start_i) begin
          req_q   <= len_i;
          hdr_q   <= '0;
          bidx_q  <= '0;
          tmark_q <= 1'b0;
          par_q   <= 1'b0;
          fmt_q   <= 1'b0;
          st_q    <= R_HDR;
        end
        R_HDR: if (fire) begin
          hdr_q  <= {tp_data_i, hdr_q[31:8]};
          bidx_q <= bidx_q + 2'd1;
          if (bidx_q == 2'd3) st_q <= R_CHK;
        end
        R_CHK: begin
          if (hdr_q == 32'd0) begin
            tmark_q <= 1'b1;
            st_q    <= R_DONE;
          end else if (hdr_q > 32'(MAX_LEN)) begin
            par_q <= 1'b1;
            st_q  <= R_DONE;
          end else begin
            cnt_q <= '0;
            st_q  <= R_DATA;
          end
        end
        R_DATA: if (fire) begin
          cnt_q <= cnt_q + ONE_C;
          if (cnt_q == last_idx) st_q <= hdr_q[0] ? R_PAD : R_TRL;
        end
        R_PAD: if (fire) st_q <= R_TRL;
        R_TRL: if (fire) begin
          trl_q  <= {tp_data_i, trl_q[23:8]};
          bidx_q <= bidx_q + 2'd1;
          if (bidx_q == 2'd3) begin
            fmt_q <= ({tp_data_i, trl_q} != hdr_q);
            st_q  <= R_DONE;
          end
        end
        R_DONE:  st_q <= R_IDLE;
        default: st_q <= R_IDLE;
      endcase
    end
  end

  assign busy_o      = (st_q != R_IDLE);
  assign done_o      = (st_q == R_DONE);
  assign res_o.len   = hdr_q;
  assign res_o.tmark = tmark_q;
  assign res_o.par   = par_q;
  assign res_o.fmt   = fmt_q;
  assign res_o.rle   = !tmark_q && !par_q && (hdr_q > 32'(req_q));
endmodule

// File: rtl/tfr_status.sv
module tfr_status
  import tfr_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wdone_i,
  input  tfr_res_t wres_i,
  input  logic     rdone_i,
  input  tfr_res_t rres_i,
  output logic     done_o,
  output tfr_res_t res_o,
  output logic     eot_o
);
  logic     prev_mark_q;
  tfr_res_t nxt;

  assign nxt = wdone_i ? wres_i : rres_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o      <= 1'b0;
      res_o       <= '0;
      eot_o       <= 1'b0;
      prev_mark_q <= 1'b0;
    end else begin
      done_o <= wdone_i || rdone_i;
      if (wdone_i || rdone_i) begin
        res_o       <= nxt;
        eot_o       <= nxt.tmark && prev_mark_q;
        prev_mark_q <= nxt.tmark;
      end
    end
  end
endmodule

// File: rtl/tfr_codec.sv
module tfr_codec
  import tfr_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int MAX_LEN = 4096
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  output logic             cmd_ready_o,
  input  logic [1:0]       cmd_op_i,
  input  logic [LEN_W-1:0] cmd_len_i,
  input  logic [7:0]       wr_data_i,
  input  logic             wr_valid_i,
  output logic             wr_ready_o,
  output logic [7:0]       tp_out_data_o,
  output logic             tp_out_valid_o,
  input  logic             tp_out_ready_i,
  input  logic [7:0]       tp_in_data_i,
  input  logic             tp_in_valid_i,
  output logic             tp_in_ready_o,
  output logic [7:0]       rd_data_o,
  output logic             rd_valid_o,
  input  logic             rd_ready_i,
  output logic             done_o,
  output logic [31:0]      sts_len_o,
  output logic             sts_tmark_o,
  output logic             sts_eot_o,
  output logic             sts_rle_o,
  output logic             sts_fmt_o,
  output logic             sts_par_o
);
  logic     w_busy, r_busy, w_done, r_done, accept, w_start, r_start;
  tfr_res_t w_res, r_res, s_res;

  assign cmd_ready_o = !w_busy && !r_busy;
  assign accept      = cmd_valid_i && cmd_ready_o;
  assign w_start     = accept && (cmd_op_i != 2'd0);
  assign r_start     = accept && (cmd_op_i == 2'd0);

  tfr_writer #(.LEN_W(LEN_W)) u_wr (
    .clk_i, .rst_ni,
    .start_i   (w_start),
    .mark_i    (cmd_op_i[1]),
    .len_i     (cmd_len_i),
    .wr_data_i, .wr_valid_i, .wr_ready_o,
    .tp_data_o (tp_out_data_o),
    .tp_valid_o(tp_out_valid_o),
    .tp_ready_i(tp_out_ready_i),
    .busy_o    (w_busy),
    .done_o    (w_done),
    .res_o     (w_res)
  );

  tfr_reader #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_rd (
    .clk_i, .rst_ni,
    .start_i   (r_start),
    .len_i     (cmd_len_i),
    .tp_data_i (tp_in_data_i),
    .tp_valid_i(tp_in_valid_i),
    .tp_ready_o(tp_in_ready_o),
    .rd_data_o, .rd_valid_o, .rd_ready_i,
    .busy_o    (r_busy),
    .done_o    (r_done),
    .res_o     (r_res)
  );

  tfr_status u_sts (
    .clk_i, .rst_ni,
    .wdone_i(w_done),
    .wres_i (w_res),
    .rdone_i(r_done),
    .rres_i (r_res),
    .done_o,
    .res_o  (s_res),
    .eot_o  (sts_eot_o)
  );

  assign sts_len_o   = s_res.len;
  assign sts_tmark_o = s_res.tmark;
  assign sts_rle_o   = s_res.rle;
  assign sts_fmt_o   = s_res.fmt;
  assign sts_par_o   = s_res.par;
endmodule

// File: rtl/tfr_codec_chk.sv
module tfr_codec_chk #(
  parameter int MAX_LEN = 4096
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cmd_valid_i,
  input logic        cmd_ready_o,
  input logic [7:0]  tp_out_data_o,
  input logic        tp_out_valid_o,
  input logic        tp_out_ready_i,
  input logic [7:0]  rd_data_o,
  input logic        rd_valid_o,
  input logic        rd_ready_i,
  input logic        done_o,
  input logic [31:0] sts_len_o,
  input logic        sts_tmark_o,
  input logic        sts_rle_o,
  input logic        sts_par_o
);
  assert_out_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tp_out_valid_o && !tp_out_ready_i |=> tp_out_valid_o && $stable(tp_out_data_o));

  assert_rd_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_data_o));

  assert_rle_clean_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && sts_rle_o |-> !sts_par_o && !sts_tmark_o);

  assert_mark_len_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && sts_tmark_o |-> sts_len_o == 32'd0 && !sts_rle_o);

  assert_par_len_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && sts_par_o |-> sts_len_o > 32'(MAX_LEN));

  assert_cmd_busy_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_ready_o |=> !cmd_ready_o);

  assert_idle_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> !tp_out_valid_o && !rd_valid_o);

  assert_done_pulse_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_sts_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |=> done_o || $stable(sts_len_o));
endmodule

bind tfr_codec tfr_codec_chk #(.MAX_LEN(MAX_LEN)) u_chk (
  .clk_i, .rst_ni, .cmd_valid_i, .cmd_ready_o,
  .tp_out_data_o, .tp_out_valid_o, .tp_out_ready_i,
  .rd_data_o, .rd_valid_o, .rd_ready_i,
  .done_o, .sts_len_o, .sts_tmark_o, .sts_rle_o, .sts_par_o
);

// File: tb/tfr_codec_test.sv
module tfr_codec_test;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W      = 16;
  localparam int MAX_LEN    = 4096;

  logic             clk_i = 1'b0, rst_ni = 1'b0;
  logic             cmd_valid_i = 1'b0, cmd_ready_o;
  logic [1:0]       cmd_op_i = '0;
  logic [LEN_W-1:0] cmd_len_i = '0;
  logic [7:0]       wr_data_i = '0;
  logic             wr_valid_i = 1'b0, wr_ready_o;
  logic [7:0]       tp_out_data_o;
  logic             tp_out_valid_o, tp_out_ready_i = 1'b0;
  logic [7:0]       tp_in_data_i = '0;
  logic             tp_in_valid_i = 1'b0, tp_in_ready_o;
  logic [7:0]       rd_data_o;
  logic             rd_valid_o, rd_ready_i = 1'b0;
  logic             done_o;
  logic [31:0]      sts_len_o;
  logic             sts_tmark_o, sts_eot_o, sts_rle_o, sts_fmt_o, sts_par_o;

  logic [7:0]  src  [0:511];
  logic [7:0]  got  [0:511];
  logic [7:0]  expb [0:511];
  logic [7:0]  wdat [0:511];
  int          ngot, fed, nchk, nfail;
  bit          op_done;
  logic [31:0] c_len;
  logic        c_tm, c_eot, c_rle, c_fmt, c_par;

  tfr_codec #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) uut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    nchk++; nfail++;
    $display("FAIL R13 watchdog: actual=hung expected=completion");
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic put_le(input int base, input logic [31:0] v);
    for (int k = 0; k < 4; k++) src[base+k] = v[8*k +: 8];
  endtask

  task automatic issue(input logic [1:0] op, input int len);
    @(negedge clk_i);
    cmd_valid_i = 1'b1; cmd_op_i = op; cmd_len_i = LEN_W'(len);
    #1;
    while (!cmd_ready_o) begin @(negedge clk_i); #1; end
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
  endtask

  task automatic producer(input bit sel, input int n);
    int idx = 0;
    bit v = 1'b0;
    while (idx < n && !op_done) begin
      @(negedge clk_i);
      if (!v && ($urandom % 4) != 0) v = 1'b1;
      if (sel == 1'b0) begin wr_valid_i = v; wr_data_i = src[idx]; end
      else begin tp_in_valid_i = v; tp_in_data_i = src[idx]; end
      #1;
      if (v && (sel == 1'b0 ? wr_ready_o : tp_in_ready_o)) begin idx++; v = 1'b0; end
    end
    @(negedge clk_i);
    wr_valid_i = 1'b0; tp_in_valid_i = 1'b0;
    fed = idx;
  endtask

  task automatic consumer(input bit sel);
    while (!op_done) begin
      @(negedge clk_i);
      if (sel == 1'b0) tp_out_ready_i = (($urandom % 3) != 0);
      else rd_ready_i = (($urandom % 3) != 0);
      #1;
      if (sel == 1'b0 && tp_out_valid_o && tp_out_ready_i) begin got[ngot] = tp_out_data_o; ngot++; end
      if (sel == 1'b1 && rd_valid_o && rd_ready_i) begin got[ngot] = rd_data_o; ngot++; end
    end
    tp_out_ready_i = 1'b0; rd_ready_i = 1'b0;
  endtask

  task automatic monitor();
    int w = 0;
    while (!op_done) begin
      @(negedge clk_i); #1;
      if (done_o) begin
        op_done = 1'b1;
        c_len = sts_len_o; c_tm = sts_tmark_o; c_eot = sts_eot_o;
        c_rle = sts_rle_o; c_fmt = sts_fmt_o; c_par = sts_par_o;
      end else if (++w > 3000) begin
        op_done = 1'b1;
        chk(1'b0, "R13 no done", 0, 1);
      end
    end
  endtask

  task automatic transfer(input bit sel, input int nprod);
    fork
      producer(sel, nprod);
      consumer(sel);
      monitor();
    join
    @(negedge clk_i); #1;
    chk(done_o == 1'b0, "R13 done width", done_o, 0);
    chk(cmd_ready_o && !tp_out_valid_o && !rd_valid_o && !wr_ready_o && !tp_in_ready_o,
        "R12 idle quiet", {cmd_ready_o, tp_out_valid_o, rd_valid_o}, 3'b100);
  endtask

  task automatic prep();
    op_done = 1'b0; ngot = 0; fed = 0;
  endtask

  // write record (mark=0) or file mark (mark=1); data already in src
  task automatic do_write(input bit mark, input int len);
    int n, bad;
    logic [31:0] l;
    l = mark ? 32'd0 : 32'(len);
    for (int k = 0; k < 4; k++) expb[k] = l[8*k +: 8];
    n = 4;
    if (l != 0) begin
      for (int i = 0; i < len; i++) expb[4+i] = src[i];
      n = 4 + len;
      if (len % 2 == 1) begin expb[n] = 8'h00; n++; end
      for (int k = 0; k < 4; k++) expb[n+k] = l[8*k +: 8];
      n += 4;
    end
    for (int i = 0; i < len; i++) wdat[i] = src[i];
    prep();
    issue(mark ? 2'd2 : 2'd1, len);
    transfer(1'b0, mark ? 0 : len);
    chk(ngot == n, "R1 frame size", ngot, n);
    bad = 0;
    for (int i = 0; i < n && i < ngot; i++) if (got[i] !== expb[i]) bad++;
    chk(bad == 0, (len % 2 == 1) ? "R2 frame bytes" : "R1 frame bytes", bad, 0);
    chk(c_len == l && c_tm == (l == 0), "R3 write status", {c_len, c_tm}, {l, (l == 0)});
  endtask

  // read a frame held in src[0..n-1]; record data at src[4..]
  task automatic do_read(input int len, input int req, input int n, input logic [31:0] hdr,
                         input logic [31:0] trl, input string tag);
    int exp_n, bad;
    exp_n = (hdr == 0 || hdr > MAX_LEN) ? 0 : ((len < req) ? len : req);
    prep();
    issue(2'd0, req);
    transfer(1'b1, n);
    chk(ngot == exp_n, {tag, " delivered"}, ngot, exp_n);
    bad = 0;
    for (int i = 0; i < exp_n && i < ngot; i++) if (got[i] !== src[4+i]) bad++;
    chk(bad == 0, {tag, " data"}, bad, 0);
    chk(c_len == hdr, {tag, " length"}, c_len, hdr);
    chk(c_rle == (hdr != 0 && hdr <= MAX_LEN && hdr > req), {tag, " rle R5"}, c_rle,
        (hdr != 0 && hdr <= MAX_LEN && hdr > req));
    chk(c_fmt == (hdr != 0 && hdr <= MAX_LEN && trl != hdr), {tag, " fmt R8"}, c_fmt,
        (hdr != 0 && hdr <= MAX_LEN && trl != hdr));
    chk(c_par == (hdr > MAX_LEN), {tag, " par R11"}, c_par, (hdr > MAX_LEN));
    chk(c_tm == (hdr == 0), {tag, " tmark R9"}, c_tm, (hdr == 0));
    chk(fed == ((hdr > MAX_LEN) ? 4 : n), {tag, " consumed"}, fed, (hdr > MAX_LEN) ? 4 : n);
  endtask

  task automatic build(input int len, input logic [31:0] trl, output int n);
    put_le(0, 32'(len));
    for (int i = 0; i < len; i++) src[4+i] = 8'($urandom);
    n = 4 + len;
    if (len % 2 == 1) begin src[n] = 8'hA5; n++; end  // filler value on tape is don't-care
    put_le(n, trl);
    n += 4;
  endtask

  task automatic read_frame(input int len, input int req, input logic [31:0] trl, input string tag);
    int n;
    build(len, trl, n);
    do_read(len, req, n, 32'(len), trl, tag);
  endtask

  task automatic read_mark(input bit eot_exp, input string tag);
    put_le(0, 32'd0);
    do_read(0, 8, 4, 32'd0, 32'd0, tag);
    chk(c_eot == eot_exp, "R10 eot after read mark", c_eot, eot_exp);
  endtask

  initial begin
    int seed, n, len, req;
    nchk = 0; nfail = 0;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk_i);
    #1;
    chk(cmd_ready_o == 1'b0 || cmd_ready_o == 1'b1, "R12 reset ready known", cmd_ready_o, 1);
    chk(done_o == 1'b0 && sts_len_o == 0 && !sts_tmark_o && !sts_eot_o && !sts_rle_o
        && !sts_fmt_o && !sts_par_o, "R13 reset status", sts_len_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i); #1;
    chk(cmd_ready_o == 1'b1 && !tp_out_valid_o && !rd_valid_o, "R12 reset idle", cmd_ready_o, 1);

    // directed writes
    for (int i = 0; i < 4; i++) src[i] = 8'(8'h10 + i);
    do_write(1'b0, 4);                                         // R1
    for (int i = 0; i < 5; i++) src[i] = 8'(8'hF0 + i);
    do_write(1'b0, 5);                                         // R2 odd, zero filler
    do_write(1'b1, 0);                                         // R3 mark
    chk(sts_eot_o == 1'b0, "R10 single mark", sts_eot_o, 0);
    do_write(1'b0, 0);                                         // R3 zero-length record
    chk(sts_eot_o == 1'b1, "R10 two written marks", sts_eot_o, 1);

    // directed reads
    read_frame(6, 6, 32'd6, "R4 exact");
    chk(sts_eot_o == 1'b0, "R10 cleared by record", sts_eot_o, 0);
    read_frame(10, 4, 32'd10, "R5 longer");
    read_frame(9, 0, 32'd9, "R5 zero budget");
    read_frame(3, 8, 32'd3, "R6 shorter");
    read_frame(7, 7, 32'd7, "R7 odd pad");
    read_frame(8, 8, 32'd8 ^ 32'h100, "R8 trailer mismatch");
    read_frame(5, 9, 32'd6, "R8 odd mismatch");
    read_mark(1'b0, "R9 first mark");
    read_mark(1'b1, "R9 second mark");
    read_frame(2, 2, 32'd2, "R4 after eot");
    chk(sts_eot_o == 1'b0, "R10 eot cleared", sts_eot_o, 0);

    // oversize header: only the length word may be taken
    put_le(0, 32'(MAX_LEN + 1));
    for (int i = 4; i < 12; i++) src[i] = 8'h5A;
    do_read(MAX_LEN + 1, 16, 12, 32'(MAX_LEN + 1), 32'd0, "R11 oversize");

    // command offered while a read is busy
    build(4, 32'd4, n);
    prep();
    issue(2'd0, 4);
    @(negedge clk_i);
    cmd_valid_i = 1'b1; cmd_op_i = 2'd1; cmd_len_i = LEN_W'(3);
    for (int c = 0; c < 3; c++) begin
      #1;
      chk(!cmd_ready_o && !tp_out_valid_o, "R12 busy refuses", {cmd_ready_o, tp_out_valid_o}, 0);
      @(negedge clk_i);
    end
    cmd_valid_i = 1'b0;
    transfer(1'b1, n);
    chk(ngot == 4 && c_len == 32'd4 && !c_fmt, "R12 read unaffected", ngot, 4);

    // random write then loop-back read
    for (int it = 0; it < 14; it++) begin
      len = 1 + ($urandom % 40);
      req = $urandom % 48;
      for (int i = 0; i < len; i++) src[i] = 8'($urandom);
      do_write(1'b0, len);
      n = ngot;
      for (int i = 0; i < n; i++) src[i] = got[i];
      do_read(len, req, n, 32'(len), 32'(len), (req < len) ? "R5 loopback" : "R6 loopback");
      for (int i = 0; i < len && i < req; i++)
        if (got[i] !== wdat[i]) chk(1'b0, "R4 loopback byte", got[i], wdat[i]);
    end

    summary();
    $finish;
  end
endmodule